// File: doc/BRIEF.md
# Linear Frequency Sweep Synthesizer

This block generates a digital waveform whose frequency steps linearly through a programmed range. A phase accumulator adds a frequency word to itself every clock. The upper phase bits are turned into a 10-bit amplitude code by a triangle or a parabolic sine-like mapping. A scan controller loads a start word and then adds an increment word a programmed number of times. Each step can come after a programmed number of clocks, or on each rising edge of the trigger input.

Software writes the start word, the increment word, the step count, the step interval and a mode word through a small write port. A rising edge on the trigger input starts the scan. A rising edge on the abort input stops it and parks the amplitude code at midscale. A square output carries the inverted MSB of the amplitude code. A sync output marks either the end of the scan or every step. Each of these two outputs has its own enable.

Top module: `dds_sweep_top`

## Requirements
- R1: After reset, amp_out is 512 (midscale), and busy, sq_out and sync_out are 0.
- R2: A write with cfg_we high stores cfg_wdata into the register selected by cfg_addr on that clock edge. The address map is: 0 start word (24 bits), 1 increment word (24 bits), 2 step count (bits 11:0), 3 step interval (bits 10:0), 4 mode. The mode bits are: bit0 auto-increment, bit1 sync on every step, bit2 sync enable, bit3 square enable, bit4 sine mapping (0 selects triangle).
- R3: Both asynchronous inputs pass through two flip-flops, and a rising edge of the synchronised value is detected. While idle, a trigger rising edge loads the start word as the active frequency word, clears the phase accumulator to zero, clears midscale parking and raises busy.
- R4: Every clock, the phase accumulator adds the active frequency word modulo 2^24. The top 11 phase bits drive the mapping. The mapped code reaches amp_out two clocks after the phase value.
- R5: Triangle mapping: for phase index p (11 bits), the code is p when p < 1024 and 2047 - p otherwise.
- R6: Sine mapping: with x the low 10 bits of p and m = (x*(1024-x)*511) >> 18, the code is 512 + m when p < 1024 and 512 - m otherwise.
- R7: In auto-increment mode, the frequency word grows by the increment every interval clocks. An interval of 0 behaves as 1. Trigger edges during the scan are ignored.
- R8: In external mode, each trigger rising edge during the scan adds one increment, and nothing else advances the word.
- R9: Once the programmed number of increments has been made, busy falls on the next clock and the final word keeps playing. A step count of 0 ends the scan one clock after it starts.
- R10: An abort rising edge makes busy low on the next edge and parks amp_out at 512 from the edge after that, until the next start.
- R11: sync_out is 0 while sync enable is clear. Otherwise it is a one-clock pulse, one clock after the end of the scan or after each increment, depending on the mode bit.
- R12: sq_out equals the inverse of the MSB of amp_out while square enable is set, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 24 | Register write data |
| ctrl_in | input | 1 | Asynchronous start / external step trigger |
| intr_in | input | 1 | Asynchronous scan abort |
| amp_out | output | 10 | Amplitude code |
| sq_out | output | 1 | Inverted amplitude MSB, gated |
| sync_out | output | 1 | End-of-scan or per-step pulse, gated |
| busy | output | 1 | High while a scan is in progress |

## Verification
The bench builds the block with its default parameters: a 24-bit frequency word, a 10-bit code, a 12-bit step count and an 11-bit interval. Large start and increment words wrap the phase within tens of clocks, so both halves of both mappings are compared against the model. The 11-bit interval also makes its largest value, 2047, reachable in a short run. Interval zero, step count zero, external stepping and an abort in the middle of a scan are each driven as separate scenarios.

// File: rtl/dds_sweep_pkg.sv
package dds_sweep_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } scan_state_t;

  typedef struct packed {
    logic wave_sine;
    logic sq_en;
    logic sync_en;
    logic per_step;
    logic auto_inc;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] ADDR_START    = 3'd0;
  localparam logic [2:0] ADDR_DELTA    = 3'd1;
  localparam logic [2:0] ADDR_COUNT    = 3'd2;
  localparam logic [2:0] ADDR_INTERVAL = 3'd3;
  localparam logic [2:0] ADDR_MODE     = 3'd4;

endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/dds_scan_fsm.sv
module dds_scan_fsm
  import dds_sweep_pkg::*;
#(
  parameter int FTW_W = 24,
  parameter int CNT_W = 12,
  parameter int INT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FTW_W-1:0] start_word,
  input  logic [FTW_W-1:0] step_word,
  input  logic [CNT_W-1:0] step_count,
  input  logic [INT_W-1:0] interval,
  input  logic             auto_inc,
  input  logic             trig_rise,
  input  logic             abort_rise,
  output logic [FTW_W-1:0] ftw,
  output logic             busy,
  output logic             mute,
  output logic             clr,
  output logic             step_p,
  output logic             eos_p
);
  scan_state_t      state;
  logic [CNT_W-1:0] left_q;
  logic [INT_W-1:0] tick_q;
  logic [INT_W-1:0] tick_last;
  logic             do_step;

  assign tick_last = (interval == '0) ? '0 : interval - 1'b1;

  always_comb begin
    do_step = 1'b0;
    if (state == ST_RUN && left_q != '0) begin
      if (auto_inc) do_step = (tick_q == tick_last);
      else          do_step = trig_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ftw    <= '0;
      left_q <= '0;
      tick_q <= '0;
      busy   <= 1'b0;
      mute   <= 1'b1;
      clr    <= 1'b0;
      step_p <= 1'b0;
      eos_p  <= 1'b0;
    end else begin
      clr    <= 1'b0;
      step_p <= 1'b0;
      eos_p  <= 1'b0;
      if (abort_rise) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        mute  <= 1'b1;
        ftw   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (trig_rise) begin
              state  <= ST_RUN;
              busy   <= 1'b1;
              mute   <= 1'b0;
              clr    <= 1'b1;
              ftw    <= start_word;
              left_q <= step_count;
              tick_q <= '0;
            end
          end
          ST_RUN: begin
            if (left_q == '0) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              eos_p <= 1'b1;
            end else if (do_step) begin
              ftw    <= ftw + step_word;
              left_q <= left_q - 1'b1;
              tick_q <= '0;
              step_p <= 1'b1;
            end else if (auto_inc) begin
              tick_q <= tick_q + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dds_phase_amp.sv
module dds_phase_amp #(
  parameter int FTW_W = 24,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FTW_W-1:0] ftw,
  input  logic             clr,
  input  logic             wave_sine,
  output logic [AMP_W-1:0] amp_raw
);
  localparam int PH_W  = AMP_W + 1;
  localparam int HALF  = 1 << AMP_W;
  localparam int MID   = 1 << (AMP_W - 1);
  localparam int PRD_W = 3 * AMP_W + 2;
  localparam int SHIFT = 2 * AMP_W - 2;

  logic [FTW_W-1:0] acc;
  logic [PH_W-1:0]  ph;
  logic [AMP_W-1:0] x;
  logic [PRD_W-1:0] prod;
  logic [AMP_W-1:0] mag;
  logic [AMP_W-1:0] tri_code;
  logic [AMP_W-1:0] sin_code;

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (clr) acc <= '0;
    else          acc <= acc + ftw;
  end

  assign ph = acc[FTW_W-1 -: PH_W];
  assign x  = ph[AMP_W-1:0];

  always_comb begin
    prod = PRD_W'(x) * PRD_W'(HALF - int'(x)) * PRD_W'(MID - 1);
    mag  = AMP_W'(prod >> SHIFT);
  end

  assign tri_code = ph[PH_W-1] ? ~x : x;
  assign sin_code = ph[PH_W-1] ? AMP_W'(MID) - mag : AMP_W'(MID) + mag;

  always_ff @(posedge clk) begin
    if (rst) amp_raw <= AMP_W'(MID);
    else     amp_raw <= wave_sine ? sin_code : tri_code;
  end
endmodule

// File: rtl/dds_sweep_top.sv
module dds_sweep_top
  import dds_sweep_pkg::*;
#(
  parameter int FTW_W = 24,
  parameter int AMP_W = 10,
  parameter int CNT_W = 12,
  parameter int INT_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [FTW_W-1:0] cfg_wdata,
  input  logic             ctrl_in,
  input  logic             intr_in,
  output logic [AMP_W-1:0] amp_out,
  output logic             sq_out,
  output logic             sync_out,
  output logic             busy
);
  localparam logic [AMP_W-1:0] MID_CODE = AMP_W'(1 << (AMP_W - 1));

  logic [FTW_W-1:0] cfg_start;
  logic [FTW_W-1:0] cfg_delta;
  logic [CNT_W-1:0] cfg_count;
  logic [INT_W-1:0] cfg_interval;
  mode_t            cfg_mode;
  logic             unused_wdata;

  logic             ctrl_rise;
  logic             intr_rise;
  logic [FTW_W-1:0] ftw;
  logic             mute;
  logic             clr;
  logic             step_p;
  logic             eos_p;
  logic [AMP_W-1:0] amp_raw;
  logic [AMP_W-1:0] amp_next;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_start    <= '0;
      cfg_delta    <= '0;
      cfg_count    <= '0;
      cfg_interval <= '0;
      cfg_mode     <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_START:    cfg_start    <= cfg_wdata;
        ADDR_DELTA:    cfg_delta    <= cfg_wdata;
        ADDR_COUNT:    cfg_count    <= cfg_wdata[CNT_W-1:0];
        ADDR_INTERVAL: cfg_interval <= cfg_wdata[INT_W-1:0];
        ADDR_MODE:     cfg_mode     <= cfg_wdata[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  dds_edge_sync #(.STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk (clk),
    .rst (rst),
    .din (ctrl_in),
    .rise(ctrl_rise)
  );

  dds_edge_sync #(.STAGES(SYNC_STAGES)) u_intr_sync (
    .clk (clk),
    .rst (rst),
    .din (intr_in),
    .rise(intr_rise)
  );

  dds_scan_fsm #(
    .FTW_W(FTW_W),
    .CNT_W(CNT_W),
    .INT_W(INT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_word(cfg_start),
    .step_word (cfg_delta),
    .step_count(cfg_count),
    .interval  (cfg_interval),
    .auto_inc  (cfg_mode.auto_inc),
    .trig_rise (ctrl_rise),
    .abort_rise(intr_rise),
    .ftw       (ftw),
    .busy      (busy),
    .mute      (mute),
    .clr       (clr),
    .step_p    (step_p),
    .eos_p     (eos_p)
  );

  dds_phase_amp #(
    .FTW_W(FTW_W),
    .AMP_W(AMP_W)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ftw      (ftw),
    .clr      (clr),
    .wave_sine(cfg_mode.wave_sine),
    .amp_raw  (amp_raw)
  );

  assign amp_next = mute ? MID_CODE : amp_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_out  <= MID_CODE;
      sq_out   <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      amp_out  <= amp_next;
      sq_out   <= cfg_mode.sq_en & ~amp_next[AMP_W-1];
      sync_out <= cfg_mode.sync_en & (cfg_mode.per_step ? step_p : eos_p);
    end
  end
endmodule

// File: rtl/dds_sweep_checks.sv
module dds_sweep_checks #(
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_rise,
  input logic             intr_rise,
  input logic             sync_en,
  input logic             per_step,
  input logic             sq_en,
  input logic [AMP_W-1:0] amp_out,
  input logic             sq_out,
  input logic             sync_out,
  input logic             busy
);
  localparam logic [AMP_W-1:0] MID_CODE = AMP_W'(1 << (AMP_W - 1));

  // R3: an idle trigger edge raises busy
  a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rise && !busy && !intr_rise) |=> busy);

  // R10: abort drops busy, then parks the code at midscale
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    intr_rise |=> !busy);
  a_r10_abort_mid: assert property (@(posedge clk) disable iff (rst)
    intr_rise |=> ##1 (amp_out == MID_CODE));

  // R11: sync stays low when disabled; end-of-scan pulse lasts one clock
  a_r11_sync_gate: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !sync_out);
  a_r11_eos_single: assert property (@(posedge clk) disable iff (rst)
    (sync_out && !per_step) |=> !sync_out);

  // R12: square output follows the inverted code MSB, or stays low
  a_r12_sq_follow: assert property (@(posedge clk) disable iff (rst)
    sq_en |=> (sq_out == !amp_out[AMP_W-1]));
  a_r12_sq_gate: assert property (@(posedge clk) disable iff (rst)
    !sq_en |=> !sq_out);
endmodule

bind dds_sweep_top dds_sweep_checks #(.AMP_W(AMP_W)) u_checks (
  .clk      (clk),
  .rst      (rst),
  .ctrl_rise(ctrl_rise),
  .intr_rise(intr_rise),
  .sync_en  (cfg_mode.sync_en),
  .per_step (cfg_mode.per_step),
  .sq_en    (cfg_mode.sq_en),
  .amp_out  (amp_out),
  .sq_out   (sq_out),
  .sync_out (sync_out),
  .busy     (busy)
);

// File: tb/dds_sweep_top_test.sv
module dds_sweep_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        ctrl_in = 1'b0;
  logic        intr_in = 1'b0;
  logic [9:0]  amp_out;
  logic        sq_out;
  logic        sync_out;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dds_sweep_top uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_in(ctrl_in), .intr_in(intr_in),
    .amp_out(amp_out), .sq_out(sq_out), .sync_out(sync_out), .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  int m_start, m_delta, m_count, m_ivl, m_mode;
  int m_c1, m_c2, m_c3, m_i1, m_i2, m_i3;
  int m_run, m_busy, m_mute, m_ftw, m_left, m_tick;
  int m_clr, m_step, m_eos, m_acc, m_raw;
  int m_amp, m_sq, m_sync;

  function automatic int wave(int acc, int sine);
    int p, x, mg;
    p = acc >> 13;
    x = p % 1024;
    if (sine == 0) return (p < 1024) ? p : 2047 - p;
    mg = (x * (1024 - x) * 511) >>> 18;
    return (p < 1024) ? 512 + mg : 512 - mg;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_delta = 0; m_count = 0; m_ivl = 0; m_mode = 0;
      m_c1 = 0; m_c2 = 0; m_c3 = 0; m_i1 = 0; m_i2 = 0; m_i3 = 0;
      m_run = 0; m_busy = 0; m_mute = 1; m_ftw = 0; m_left = 0; m_tick = 0;
      m_clr = 0; m_step = 0; m_eos = 0; m_acc = 0; m_raw = 512;
      m_amp = 512; m_sq = 0; m_sync = 0;
    end else begin
      int cr, ir, nxt, lim, go;
      cr = m_c2 & ~m_c3;
      ir = m_i2 & ~m_i3;
      // output stage uses the old mute, raw and pulses
      nxt    = m_mute ? 512 : m_raw;
      m_sync = ((m_mode >> 2) & 1) ? (((m_mode >> 1) & 1) ? m_step : m_eos) : 0;
      m_amp  = nxt;
      m_sq   = ((m_mode >> 3) & 1) & ((nxt < 512) ? 1 : 0);
      m_raw  = wave(m_acc, (m_mode >> 4) & 1);
      m_acc  = m_clr ? 0 : ((m_acc + m_ftw) & 24'hFFFFFF);
      m_clr = 0; m_step = 0; m_eos = 0;
      if (ir) begin
        m_run = 0; m_busy = 0; m_mute = 1; m_ftw = 0;
      end else if (!m_run) begin
        if (cr) begin
          m_run = 1; m_busy = 1; m_mute = 0; m_clr = 1;
          m_ftw = m_start; m_left = m_count; m_tick = 0;
        end
      end else if (m_left == 0) begin
        m_run = 0; m_busy = 0; m_eos = 1;
      end else begin
        lim = (m_ivl == 0) ? 1 : m_ivl;
        go  = (m_mode & 1) ? (m_tick == lim - 1) : cr;
        if (go) begin
          m_ftw = (m_ftw + m_delta) & 24'hFFFFFF;
          m_left--; m_tick = 0; m_step = 1;
        end else if (m_mode & 1) m_tick++;
      end
      m_c3 = m_c2; m_c2 = m_c1; m_c1 = ctrl_in;
      m_i3 = m_i2; m_i2 = m_i1; m_i1 = intr_in;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_start = cfg_wdata;
          3'd1: m_delta = cfg_wdata;
          3'd2: m_count = cfg_wdata & 12'hFFF;
          3'd3: m_ivl   = cfg_wdata & 11'h7FF;
          3'd4: m_mode  = cfg_wdata & 5'h1F;
          default: ;
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (amp_out != m_amp[9:0] || sq_out != m_sq[0] ||
          sync_out != m_sync[0] || busy != m_busy[0]) begin
        errors++;
        $display("FAIL %s amp/sq/sync/busy actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 cur_req, amp_out, sq_out, sync_out, busy, m_amp, m_sq, m_sync, m_busy);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ctrl();
    @(negedge clk); ctrl_in = 1'b1;
    idle(3);        ctrl_in = 1'b0;
    idle(3);
  endtask

  task automatic pulse_intr();
    @(negedge clk); intr_in = 1'b1;
    idle(3);        intr_in = 1'b0;
  endtask

  task automatic expect_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    cur_req = "R1";
    expect_bit("R1 amp midscale", amp_out == 10'd512, 1'b1);
    expect_bit("R1 busy", busy, 1'b0);
    expect_bit("R1 sync", sync_out, 1'b0);
    expect_bit("R1 sq", sq_out, 1'b0);

    // R2 R3 R4 R5 R7 R9 R11 R12: auto scan, triangle, end-of-scan sync
    cur_req = "R2/R3/R4/R5/R7/R9/R11/R12 auto triangle";
    wr(3'd0, 24'h100000);
    wr(3'd1, 24'h080000);
    wr(3'd2, 24'd3);
    wr(3'd3, 24'd5);
    wr(3'd4, 24'b01101);
    pulse_ctrl();
    expect_bit("R3 busy after start", busy, 1'b1);
    pulse_ctrl();  // R7: ignored during auto scan
    idle(60);
    expect_bit("R9 busy low at end", busy, 1'b0);

    // R6 R7 R11: sine, interval 0 acts as 1, per-step sync
    cur_req = "R6/R7/R11 sine per-step";
    wr(3'd3, 24'd0);
    wr(3'd2, 24'd4);
    wr(3'd1, 24'h0C0000);
    wr(3'd4, 24'b11111);
    pulse_ctrl();
    idle(80);

    // R8: external stepping
    cur_req = "R8 external";
    wr(3'd2, 24'd3);
    wr(3'd4, 24'b01100);
    pulse_ctrl();
    idle(10);
    for (int k = 0; k < 3; k++) begin
      pulse_ctrl();
      idle(15);
    end
    idle(10);
    expect_bit("R8 busy low after steps", busy, 1'b0);

    // R9: zero step count ends at once
    cur_req = "R9 zero count";
    wr(3'd2, 24'd0);
    wr(3'd4, 24'b00101);
    pulse_ctrl();
    idle(10);
    expect_bit("R9 zero count idle", busy, 1'b0);

    // R10: abort mid-scan, sync and square disabled (R11 R12 gating)
    cur_req = "R10/R11/R12 abort gated";
    wr(3'd2, 24'd10);
    wr(3'd3, 24'd20);
    wr(3'd4, 24'b00001);
    pulse_ctrl();
    idle(50);
    pulse_intr();
    idle(8);
    expect_bit("R10 busy after abort", busy, 1'b0);
    expect_bit("R10 amp parked", amp_out == 10'd512, 1'b1);
    expect_bit("R12 sq gated", sq_out, 1'b0);
    idle(20);

    // R7 R9: largest interval
    cur_req = "R7/R9 interval 2047";
    wr(3'd2, 24'd2);
    wr(3'd3, 24'd2047);
    wr(3'd4, 24'b01111);
    pulse_ctrl();
    idle(2047 * 2 + 40);
    expect_bit("R9 long scan ended", busy, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule